// File: doc/BRIEF.md
# Subspace Replacement Sequencer

This block decides whether an address-space designator has to be swapped for the designator of the subspace in which a dispatchable unit last ran, and performs the swap. A request carries the designator, an ASTE origin that an earlier ASN translation produced, the enable for the address-space functions, a control word that holds the dispatchable-unit control table (DUCT) origin, the prefix value and the top of installed storage. From these the sequencer walks two control blocks in memory through a single-word read port. It then returns either the original designator, the designator from the subspace ASTE, or zero together with an exception code.

Every control-block origin the block computes is prefixed before use. Page 0 and the page that the prefix names trade places, and every other page maps to itself. The prefixed origin is compared against the storage limit before any read is made from it. Words are 32 bits wide. Word k of a control block is fetched from origin + 4k. The caller raises `start` for one cycle and waits for the one-cycle `done` pulse. Program-interrupt delivery and ASN translation stay with the caller.

Top module: `subspace_replacer`

## Requirements
- R1: When `asf_en` is 0 or bit 9 of `desig_in` (bit 0 = LSB) is 0, the result is `desig_in` unchanged, `exc_code` is 0, no memory read is issued, and `done` is high two cycles after the cycle in which `start` was sampled.
- R2: The DUCT origin is `ctl_duct` with its six low bits forced to 0, then prefixed. If that address is greater than `stor_limit`, the result is 0, `exc_code` is 8'h05, and no read is issued.
- R3: Three DUCT words are read: 0, 1 and 3. The result is `desig_in` unchanged with code 0 in two cases: bit 31 of word 1 (subspace active) is 0, or `aste_org` differs from word 0 with its six low bits cleared.
- R4: The subspace ASTE origin is bits 30..6 of DUCT word 1, with bits 31 and 5..0 cleared, then prefixed. If it is greater than `stor_limit`, the result is 0 and the code is 8'h05; `done` follows three cycles after the acknowledge of the last DUCT read.
- R5: ASTE words 0, 2 and 5 are read in that order, with word 3 read between 2 and 5 in the wide variant. If bit 31 of ASTE word 0 is 1, the result is 0 and the code is 8'h2B. This check takes priority over R6.
- R6: If ASTE word 5 differs from DUCT word 3, the result is 0 and the code is 8'h2C.
- R7: Otherwise the result is ASTE word 2 (narrow variant) or {word 2, word 3} (wide variant). Bits 7 and 0 of the result are taken from `desig_in` instead, and the code is 0.
- R8: `exc_code` reads 0 from the cycle after `start` is accepted until the operation ends.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen, and only one read is outstanding at a time. A full walk issues 6 reads in the narrow variant.
- R10: Prefixing maps addresses in page 0 (4096 bytes) into the prefix page and addresses in the prefix page into page 0. Every other address passes through unchanged.
- R11: `done` lasts exactly one cycle. When a walk ends with reads, `done` is high two cycles after the cycle in which the last `mem_ack` was high (R4 excepted). `start` is ignored while an operation is in progress.
- R12: `desig_out` and `exc_code` hold their values between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, sampled only while idle |
| asf_en | input | 1 | Address-space-function enable |
| ctl_duct | input | 32 | Control word holding the DUCT origin in bits 31..6 |
| aste_org | input | AW | ASTE origin from ASN translation |
| desig_in | input | DESW | Designator to be checked |
| prefix | input | AW | Prefix value (page-aligned) |
| stor_limit | input | AW | Highest valid storage address |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| desig_out | output | DESW | Resulting designator |
| exc_code | output | 8 | 0, 8'h05 addressing, 8'h2B ASTE validity, 8'h2C ASTE sequence |
| done | output | 1 | One-cycle completion pulse |

## Verification
In the bench, `done` is due two cycles after `start` when the walk ends with no read: the bypass case and a DUCT origin out of range. When the walk ends after reads, `done` is due two cycles after the last acknowledge, or three when the subspace ASTE origin is out of range. The bench counts cycles from the start strobe or the last acknowledge to the `done` pulse and compares that count against the latency its model predicts for each outcome. The bench drives every input and samples every output on the falling edge, so each comparison falls half a cycle away from the edge that updated the register.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

   localparam int WORD_W  = 32;
   localparam int ORG_LSB = 6;

   localparam logic [WORD_W-1:0] ORG_MASK   = 32'hFFFF_FFC0;
   localparam logic [WORD_W-1:0] SUBORG_MSK = 32'h7FFF_FFC0;

   localparam logic [7:0] XC_NONE = 8'h00;
   localparam logic [7:0] XC_ADDR = 8'h05;
   localparam logic [7:0] XC_AVAL = 8'h2B;
   localparam logic [7:0] XC_ASEQ = 8'h2C;

   typedef enum logic [3:0] {
      S_IDLE, S_EVAL,
      S_D0, S_D1, S_D3,
      S_CHKA,
      S_A0, S_A2, S_A3, S_A5
   } ssr_state_e;

endpackage

// File: rtl/ssr_prefix_map.sv
module ssr_prefix_map #(
   parameter int AW        = 32,
   parameter int PAGE_BITS = 12
) (
   input  logic [AW-1:0] addr_in,
   input  logic [AW-1:0] prefix,
   output logic [AW-1:0] addr_out
);
   localparam int HI_W = AW - PAGE_BITS;

   logic [HI_W-1:0]      pg_in;
   logic [HI_W-1:0]      pg_pfx;
   logic [PAGE_BITS-1:0] offs;
   logic [PAGE_BITS-1:0] unused_pfx_low;

   assign pg_in          = addr_in[AW-1:PAGE_BITS];
   assign offs           = addr_in[PAGE_BITS-1:0];
   assign pg_pfx         = prefix[AW-1:PAGE_BITS];
   assign unused_pfx_low = prefix[PAGE_BITS-1:0];

   always_comb begin
      if (pg_in == '0)
         addr_out = {pg_pfx, offs};
      else if (pg_in == pg_pfx)
         addr_out = {{HI_W{1'b0}}, offs};
      else
         addr_out = addr_in;
   end
endmodule

// File: rtl/ssr_word_reader.sv
module ssr_word_reader #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] go_addr,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          rd_valid,
   output logic [31:0]   rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req  <= 1'b0;
         mem_addr <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (mem_req && mem_ack) begin
            mem_req  <= 1'b0;
            rd_data  <= mem_rdata;
            rd_valid <= 1'b1;
         end else if (go && !mem_req) begin
            mem_req  <= 1'b1;
            mem_addr <= go_addr;
         end
      end
   end

   // R9: request and address held until acknowledged
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R9: a new read is never requested while one is outstanding
   p_one_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !mem_req);

   p_ack_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> (rd_valid && !mem_req));
endmodule

// File: rtl/ssr_desig_merge.sv
module ssr_desig_merge #(
   parameter int DESW    = 32,
   parameter bit WIDE    = 1'b0,
   parameter int SSE_POS = 7,
   parameter int SAE_POS = 0
) (
   input  logic [DESW-1:0] orig,
   input  logic [31:0]     w_hi,
   input  logic [31:0]     w_lo,
   input  logic            inval,
   input  logic [31:0]     seq_got,
   input  logic [31:0]     seq_ref,
   output logic [DESW-1:0] result,
   output logic [7:0]      code
);
   import ssr_pkg::*;

   localparam logic [DESW-1:0] KEEP =
      (DESW'(1) << SSE_POS) | (DESW'(1) << SAE_POS);

   logic [DESW-1:0] ast;

   generate
      if (WIDE) begin : g_wide
         assign ast = {w_hi, w_lo};
      end else begin : g_narrow
         logic unused_lo;
         assign ast       = w_hi;
         assign unused_lo = ^w_lo;
      end
   endgenerate

   always_comb begin
      if (inval) begin
         result = '0;
         code   = XC_AVAL;
      end else if (seq_got != seq_ref) begin
         result = '0;
         code   = XC_ASEQ;
      end else begin
         result = (ast & ~KEEP) | (orig & KEEP);
         code   = XC_NONE;
      end
   end
endmodule

// File: rtl/subspace_replacer.sv
module subspace_replacer #(
   parameter int AW        = 32,
   parameter int PAGE_BITS = 12,
   parameter bit WIDE      = 1'b0,
   parameter int SSG_POS   = 9,
   parameter int SSE_POS   = 7,
   parameter int SAE_POS   = 0,
   localparam int DESW     = WIDE ? 64 : 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            asf_en,
   input  logic [31:0]     ctl_duct,
   input  logic [AW-1:0]   aste_org,
   input  logic [DESW-1:0] desig_in,
   input  logic [AW-1:0]   prefix,
   input  logic [AW-1:0]   stor_limit,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   input  logic            mem_ack,
   input  logic [31:0]     mem_rdata,
   output logic [DESW-1:0] desig_out,
   output logic [7:0]      exc_code,
   output logic            done
);
   import ssr_pkg::*;

   generate
      if (AW > 32 || AW <= PAGE_BITS + ORG_LSB) begin : g_bad_aw
         initial $fatal(1, "subspace_replacer: AW out of range");
      end
      if (SSG_POS >= DESW || SSE_POS >= DESW || SAE_POS >= DESW) begin : g_bad_pos
         initial $fatal(1, "subspace_replacer: bit position out of range");
      end
      if (SSE_POS == SAE_POS) begin : g_bad_evt
         initial $fatal(1, "subspace_replacer: event bits must differ");
      end
   endgenerate

   ssr_state_e      state_q;
   logic [DESW-1:0] orig_q;
   logic [AW-1:0]   aste_q, pfx_q, lim_q, duct_q, ssa_q;
   logic [31:0]     ctl_q, w0_q, w1_q, w3_q, a2_q, a3_q;
   logic            asf_q, a0_inv_q, pend_q;
   logic [DESW-1:0] res_q;
   logic [7:0]      exc_q;
   logic            done_q;

   logic [AW-1:0]   duct_raw, duct_pfx, ssa_raw, ssa_pfx;
   logic            bypass, aste_match;
   logic            is_rd, go;
   logic [AW-1:0]   rd_base, go_addr;
   logic [4:0]      rd_off;
   logic            rd_valid;
   logic [31:0]     rd_data;
   logic [DESW-1:0] mg_res;
   logic [7:0]      mg_code;

   assign duct_raw   = AW'(ctl_q & ORG_MASK);
   assign ssa_raw    = AW'(w1_q & SUBORG_MSK);
   assign bypass     = !asf_q || !orig_q[SSG_POS];
   assign aste_match = (aste_q == AW'(w0_q & ORG_MASK));

   ssr_prefix_map #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_pfx_duct (
      .addr_in(duct_raw), .prefix(pfx_q), .addr_out(duct_pfx));

   ssr_prefix_map #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_pfx_aste (
      .addr_in(ssa_raw), .prefix(pfx_q), .addr_out(ssa_pfx));

   always_comb begin
      is_rd  = 1'b1;
      rd_off = 5'd0;
      case (state_q)
         S_D0: rd_off = 5'd0;
         S_D1: rd_off = 5'd4;
         S_D3: rd_off = 5'd12;
         S_A0: rd_off = 5'd0;
         S_A2: rd_off = 5'd8;
         S_A3: rd_off = 5'd12;
         S_A5: rd_off = 5'd20;
         default: is_rd = 1'b0;
      endcase
   end

   assign rd_base = (state_q inside {S_D0, S_D1, S_D3}) ? duct_q : ssa_q;
   assign go_addr = rd_base + AW'(rd_off);
   assign go      = is_rd && !pend_q;

   ssr_word_reader #(.AW(AW)) u_reader (
      .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data));

   ssr_desig_merge #(.DESW(DESW), .WIDE(WIDE), .SSE_POS(SSE_POS),
                     .SAE_POS(SAE_POS)) u_merge (
      .orig(orig_q), .w_hi(a2_q), .w_lo(a3_q), .inval(a0_inv_q),
      .seq_got(rd_data), .seq_ref(w3_q), .result(mg_res), .code(mg_code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         orig_q   <= '0;
         aste_q   <= '0;
         pfx_q    <= '0;
         lim_q    <= '0;
         duct_q   <= '0;
         ssa_q    <= '0;
         ctl_q    <= '0;
         w0_q     <= '0;
         w1_q     <= '0;
         w3_q     <= '0;
         a2_q     <= '0;
         a3_q     <= '0;
         asf_q    <= 1'b0;
         a0_inv_q <= 1'b0;
         pend_q   <= 1'b0;
         res_q    <= '0;
         exc_q    <= XC_NONE;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go)
            pend_q <= 1'b1;
         else if (rd_valid)
            pend_q <= 1'b0;

         case (state_q)
            S_IDLE: begin
               if (start) begin
                  orig_q  <= desig_in;
                  asf_q   <= asf_en;
                  ctl_q   <= ctl_duct;
                  aste_q  <= aste_org;
                  pfx_q   <= prefix;
                  lim_q   <= stor_limit;
                  exc_q   <= XC_NONE;
                  state_q <= S_EVAL;
               end
            end
            S_EVAL: begin
               if (bypass) begin
                  res_q   <= orig_q;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else if (duct_pfx > lim_q) begin
                  res_q   <= '0;
                  exc_q   <= XC_ADDR;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  duct_q  <= duct_pfx;
                  state_q <= S_D0;
               end
            end
            S_D0: if (rd_valid) begin
               w0_q    <= rd_data;
               state_q <= S_D1;
            end
            S_D1: if (rd_valid) begin
               w1_q    <= rd_data;
               state_q <= S_D3;
            end
            S_D3: if (rd_valid) begin
               w3_q <= rd_data;
               if (!w1_q[31] || !aste_match) begin
                  res_q   <= orig_q;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  state_q <= S_CHKA;
               end
            end
            S_CHKA: begin
               if (ssa_pfx > lim_q) begin
                  res_q   <= '0;
                  exc_q   <= XC_ADDR;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  ssa_q   <= ssa_pfx;
                  state_q <= S_A0;
               end
            end
            S_A0: if (rd_valid) begin
               a0_inv_q <= rd_data[31];
               state_q  <= S_A2;
            end
            S_A2: if (rd_valid) begin
               a2_q    <= rd_data;
               state_q <= WIDE ? S_A3 : S_A5;
            end
            S_A3: if (rd_valid) begin
               a3_q    <= rd_data;
               state_q <= S_A5;
            end
            S_A5: if (rd_valid) begin
               res_q   <= mg_res;
               exc_q   <= mg_code;
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign desig_out = res_q;
   assign exc_code  = exc_q;
   assign done      = done_q;

   // R11: completion strobe lasts a single cycle
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5/R6/R2: any exception returns a zero designator
   p_exc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && exc_code != XC_NONE) |-> (desig_out == '0));

   // R8: code cleared as soon as an operation is accepted
   p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && start) |=> (exc_code == XC_NONE));

   // R1: bypass finishes without touching memory
   p_bypass_noreq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_EVAL && bypass) |=> (done && !mem_req));

   // R12: results hold while idle
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && !start && !done) |=>
         ($stable(desig_out) && $stable(exc_code)));
endmodule

// File: tb/subspace_replacer_tb.sv
`timescale 1ns/1ps
module subspace_replacer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        asf_en = 1'b0;
   logic [31:0] ctl_duct = '0;
   logic [31:0] aste_org = '0;
   logic [31:0] desig_in = '0;
   logic [31:0] prefix = '0;
   logic [31:0] stor_limit = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [31:0] desig_out;
   logic [7:0]  exc_code;
   logic        done;

   logic [31:0] mem [0:4095];
   int unsigned cyc = 0;
   int unsigned ack_cyc = 0;
   int unsigned nreads = 0;
   int unsigned wait_cnt = 0;
   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   subspace_replacer u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .asf_en(asf_en),
      .ctl_duct(ctl_duct), .aste_org(aste_org), .desig_in(desig_in),
      .prefix(prefix), .stor_limit(stor_limit), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .desig_out(desig_out), .exc_code(exc_code), .done(done));

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         if (wait_cnt == 0) begin
            mem_ack   = 1'b1;
            mem_rdata = mem[mem_addr[13:2]];
            ack_cyc   = cyc;
            nreads++;
            wait_cnt  = $urandom % 3;
         end else begin
            wait_cnt--;
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pfx(input logic [31:0] a, input logic [31:0] p);
      if (a[31:12] == 20'h0) return {p[31:12], a[11:0]};
      else if (a[31:12] == p[31:12]) return {20'h0, a[11:0]};
      else return a;
   endfunction

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem[a[13:2]];
   endfunction

   task automatic model(input logic asf, input logic [31:0] dsg, input logic [31:0] ctl,
                        input logic [31:0] ain, input logic [31:0] p, input logic [31:0] lim,
                        output logic [31:0] r, output logic [7:0] c, output int nr,
                        output int lat, output string tag);
      logic [31:0] d, w0, w1, w3, a, a0, a2, a5;
      lat = 2; nr = 0; c = 8'h00; r = dsg;
      if (!asf || !dsg[9]) begin tag = "R1"; return; end
      d = pfx(ctl & 32'hFFFF_FFC0, p);
      if (d > lim) begin r = 0; c = 8'h05; tag = "R2"; return; end
      w0 = rd(d); w1 = rd(d + 4); w3 = rd(d + 12); nr = 3;
      if (!w1[31] || ain != (w0 & 32'hFFFF_FFC0)) begin tag = "R3"; return; end
      a = pfx(w1 & 32'h7FFF_FFC0, p);
      if (a > lim) begin r = 0; c = 8'h05; lat = 3; tag = "R4"; return; end
      a0 = rd(a); a2 = rd(a + 8); a5 = rd(a + 20); nr = 6;
      if (a0[31]) begin r = 0; c = 8'h2B; tag = "R5"; return; end
      if (a5 != w3) begin r = 0; c = 8'h2C; tag = "R6"; return; end
      r = (a2 & ~32'h81) | (dsg & 32'h81); tag = "R7";
   endtask

   task automatic run_op(input logic asf, input logic [31:0] dsg, input logic [31:0] ctl,
                         input logic [31:0] ain, input logic [31:0] p, input logic [31:0] lim);
      logic [31:0] er; logic [7:0] ec; int enr, elat; string tag;
      int unsigned s, base; int guard;
      model(asf, dsg, ctl, ain, p, lim, er, ec, enr, elat, tag);
      @(negedge clk);
      asf_en = asf; desig_in = dsg; ctl_duct = ctl; aste_org = ain;
      prefix = p; stor_limit = lim; start = 1'b1; s = cyc; nreads = 0;
      @(negedge clk);
      desig_in = ~dsg; asf_en = ~asf;
      chk("R8 code cleared", {56'h0, exc_code}, 64'h0);
      @(negedge clk);
      start = 1'b0; desig_in = dsg; asf_en = asf;
      guard = 0;
      while (!done && guard < 300) begin @(negedge clk); guard++; end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog %s actual=busy expected=done", tag);
         return;
      end
      chk({tag, " result"}, {32'h0, desig_out}, {32'h0, er});
      chk({tag, " code"}, {56'h0, exc_code}, {56'h0, ec});
      chk("R9 read count", 64'(nreads), 64'(enr));
      base = (enr == 0) ? s : ack_cyc;
      chk({"R11 latency ", tag}, 64'(cyc - base), 64'(elat));
      @(negedge clk);
      chk("R11 done width", {63'h0, done}, 64'h0);
      @(negedge clk);
      chk("R12 hold", {24'h0, exc_code, desig_out}, {24'h0, ec, er});
   endtask

   initial begin
      #(4 * 200000);
      total++; bad++;
      $display("FAIL watchdog global actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] p, lim, dorg, sorg, borg, seq, dsg, pd, ps;
      int kind;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4096; i++) mem[i] = $urandom;
      repeat (3) @(negedge clk);
      chk("reset done", {63'h0, done}, 64'h0);
      chk("reset req", {63'h0, mem_req}, 64'h0);
      chk("reset code", {56'h0, exc_code}, 64'h0);
      chk("reset desig", {32'h0, desig_out}, 64'h0);
      rst_n = 1'b1;

      // R10 directed: DUCT in page 0 lands in the prefix page
      p = 32'h2000; dorg = 32'h0040; sorg = 32'h3100; borg = 32'h1A40; seq = 32'h5EED_0001;
      mem[(32'h2040) >> 2] = borg | 32'h3;
      mem[(32'h2044) >> 2] = 32'h8000_0000 | sorg;
      mem[(32'h204C) >> 2] = seq;
      mem[(32'h0040) >> 2] = 32'hDEAD_BEEF;
      mem[(32'h3100) >> 2] = 32'h0;
      mem[(32'h3108) >> 2] = 32'hCAFE_F00F;
      mem[(32'h3114) >> 2] = seq;
      run_op(1'b1, 32'h0000_0280, dorg | 32'h15, borg, p, 32'h3FFF);
      chk("R10 prefixed walk", {32'h0, desig_out}, {32'h0, 32'hCAFE_F08E});
      // R1 directed: enable off
      run_op(1'b0, 32'hFFFF_FFFF, dorg, borg, p, 32'h3FFF);
      // R2 directed: limit below DUCT
      run_op(1'b1, 32'h0000_0200, 32'h0000_1000, borg, p, 32'h0FFF);

      for (int it = 0; it < 80; it++) begin
         kind = $urandom % 8;
         p    = (($urandom % 3) + 1) << 12;
         dorg = ($urandom % 256) << 6;
         sorg = ($urandom % 256) << 6;
         borg = ($urandom % 256) << 6;
         seq  = $urandom;
         lim  = 32'h3FFF;
         pd = pfx(dorg, p); ps = pfx(sorg, p);
         mem[ps[13:2]]       = {(kind == 5), 31'($urandom)};
         mem[(ps + 8) >> 2]  = $urandom;
         mem[(ps + 20) >> 2] = (kind == 6) ? ~seq : seq;
         mem[pd[13:2]]       = borg | ($urandom % 64);
         mem[(pd + 4) >> 2]  = {(kind != 3), sorg[30:6], 6'($urandom)};
         mem[(pd + 12) >> 2] = seq;
         dsg = $urandom | 32'h200;
         if (kind == 0) dsg[9] = 1'b0;
         if (kind == 2) lim = (pd > 0) ? pd - 1 : 0;
         if (kind == 4 && ps > 0) lim = ps - 1;
         run_op(!(kind == 1), dsg, dorg | ($urandom % 64),
                (kind == 7 && it % 2 == 1) ? borg ^ 32'h40 : borg, p, lim);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule